// File: doc/BRIEF.md
# ATA Taskfile Load and Readback Sequencer

This block turns a taskfile operation into an ordered series of single register cycles and hands them one at a time to a PIO register cycle engine below it. The caller latches a complete taskfile: the low-order and high-order byte sets, the device byte, the control byte and the command byte. It also supplies three flags: address-valid, 48-bit addressing and device-valid. It then starts one of three operations. A load writes the taskfile into the drive and then polls status until the drive is no longer busy. A readback reads the shadow registers into a capture store, including the high-order copies when 48-bit addressing is set. A command issue writes the command byte.

The sequencer keeps its own copy of the last control byte sent to the drive. It skips a control write that would repeat that value. For a 48-bit readback it sets the high-order-byte select bit in control, reads the five high-order registers, and then restores control.

Top module: `ata_tf_sequencer`

## Requirements
- R1: Register addresses on `eng_addr_o` are 4 bits. Codes 1 to 5 are feature/error, sector count, LBA low, LBA mid and LBA high. Code 6 is device, code 7 is status/command and code 14 (4'hE) is device control.
- R2: In a load (op 0), control is written first, and only if `ctl_i` differs from the last control byte written. After that write the copy takes the new value. After reset the copy holds CTL_RST (default 8'h08).
- R3: In a load with address-valid and 48-bit set, the five high-order bytes of `tf_hi_i` (byte k at bits 8k+7:8k, sent to code k+1) are written for codes 1 to 5 in ascending order. This happens before the low-order writes.
- R4: In a load with address-valid set, the five bytes of `tf_lo_i` are written for codes 1 to 5 in ascending order. Without address-valid, no address write of either set occurs, whatever the 48-bit flag.
- R5: In a load, the device byte is written to code 6 after every address write, and only when device-valid is set.
- R6: A load ends by reading status (code 7). It repeats the read while bit 7 (busy) is 1, up to MAX_POLLS reads in all. If every one of those reads shows busy, `err_o` is 1 together with `done_o`. Otherwise `err_o` is 0.
- R7: A readback (op 1) reads code 7, then codes 1 to 6. The results go into slots 0 to 6 of `rb_o` (slot s at bits 8s+7:8s).
- R8: A readback with 48-bit set then writes control as `ctl_i` OR 8'h80, reads codes 1 to 5 into slots 7 to 11, and writes control as `ctl_i`. The last-control copy becomes `ctl_i`.
- R9: A command issue (op 2) is exactly one write of `cmd_i` to code 7.
- R10: Each register cycle is a one-cycle pulse on `eng_req_o`. No further request is raised until `eng_done_i` has returned for the current one.
- R11: A `start_i` pulse while `busy_o` is 1 is ignored. A `start_i` pulse in the cycle where `done_o` is 1 starts a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; latches op, taskfile and flags |
| op_i | input | 2 | 0 load, 1 readback, 2 command, 3 no operation |
| tf_lo_i | input | 40 | Low-order feature, count, LBA low/mid/high (byte 0 = feature) |
| tf_hi_i | input | 40 | High-order copies, same layout |
| dev_i | input | 8 | Device byte |
| ctl_i | input | 8 | Device control byte |
| cmd_i | input | 8 | Command byte |
| addr_v_i | input | 1 | Address-valid flag |
| lba48_i | input | 1 | 48-bit addressing flag |
| dev_v_i | input | 1 | Device-valid flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Busy-wait timeout of the last load |
| rb_o | output | 96 | Capture store, 12 byte slots |
| eng_req_o | output | 1 | Register cycle request pulse |
| eng_wr_o | output | 1 | Cycle is a write |
| eng_addr_o | output | 4 | Register address code |
| eng_wdata_o | output | 8 | Write data |
| eng_done_i | input | 1 | Cycle engine completion pulse |
| eng_rdata_i | input | 8 | Read data, valid with eng_done_i |

## Verification
The collision that matters is a new start pulse landing in the very cycle the completion pulse of the previous operation is high. The bench raises `start_i` at the sample where it first sees `done_o`. It judges the start taken if `busy_o` is high one cycle later and the full readback register sequence follows. A second pulse is sent in the middle of a running load. For that one, the bench judges the register log against the load alone, so the pulse must leave no trace.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_READ = 2'd1, OP_CMD = 2'd2, OP_NONE = 2'd3} op_e;

  localparam logic [3:0] A_DEV  = 4'd6;
  localparam logic [3:0] A_STAT = 4'd7;
  localparam logic [3:0] A_CTL  = 4'hE;
  localparam logic [7:0] HOB_BIT = 8'h80;

  // data source codes: 0..4 low set, 5..9 high set, 10 device, 11 control,
  // 12 control with high-byte select, 13 command
  localparam logic [3:0] D_DEV = 4'd10;
  localparam logic [3:0] D_CTL = 4'd11;
  localparam logic [3:0] D_HOB = 4'd12;
  localparam logic [3:0] D_CMD = 4'd13;

  typedef struct packed {
    logic       en;
    logic       wr;
    logic [3:0] addr;
    logic [3:0] dsel;
    logic       cap;
    logic [3:0] slot;
    logic       poll;
    logic       upd;
    logic       fin;
  } step_t;
endpackage

// File: rtl/ata_step_decode.sv
module ata_step_decode
  import ata_seq_pkg::*;
(
  input  op_e        op,
  input  logic [3:0] idx,
  input  logic       addr_v,
  input  logic       lba48,
  input  logic       dev_v,
  input  logic       ctl_dirty,
  output step_t      st
);
  always_comb begin
    st = '0;
    case (op)
      OP_LOAD: begin
        st.wr = 1'b1;
        if (idx == 4'd0) begin
          st.en = ctl_dirty; st.addr = A_CTL; st.dsel = D_CTL; st.upd = 1'b1;
        end else if (idx <= 4'd5) begin
          st.en = addr_v & lba48; st.addr = idx; st.dsel = idx + 4'd4;
        end else if (idx <= 4'd10) begin
          st.en = addr_v; st.addr = idx - 4'd5; st.dsel = idx - 4'd6;
        end else if (idx == 4'd11) begin
          st.en = dev_v; st.addr = A_DEV; st.dsel = D_DEV;
        end else begin
          st.en = 1'b1; st.wr = 1'b0; st.addr = A_STAT;
          st.cap = 1'b1; st.slot = 4'd0; st.poll = 1'b1; st.fin = 1'b1;
        end
      end
      OP_READ: begin
        if (idx <= 4'd6) begin
          st.en = 1'b1; st.cap = 1'b1; st.slot = idx;
          st.addr = (idx == 4'd0) ? A_STAT : idx;
        end else if (idx == 4'd7) begin
          st.en = lba48; st.wr = 1'b1; st.addr = A_CTL; st.dsel = D_HOB;
        end else if (idx <= 4'd12) begin
          st.en = lba48; st.cap = 1'b1; st.addr = idx - 4'd7; st.slot = idx - 4'd1;
        end else begin
          st.en = lba48; st.wr = 1'b1; st.addr = A_CTL; st.dsel = D_CTL;
          st.upd = 1'b1; st.fin = 1'b1;
        end
      end
      OP_CMD: begin
        st.en = 1'b1; st.wr = 1'b1; st.addr = A_STAT; st.dsel = D_CMD; st.fin = 1'b1;
      end
      default: st.fin = 1'b1;
    endcase
  end
endmodule

// File: rtl/ata_rb_store.sv
module ata_rb_store #(
  parameter int NSLOT = 12,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_i,
  input  logic [3:0]         slot_i,
  input  logic [W-1:0]       d_i,
  output logic [NSLOT*W-1:0] rb_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) rb_o[s*W +: W] <= '0;
      else if (cap_i && slot_i == 4'(s)) rb_o[s*W +: W] <= d_i;
    end
  end
endmodule

// File: rtl/ata_tf_sequencer.sv
module ata_tf_sequencer
  import ata_seq_pkg::*;
#(
  parameter int         MAX_POLLS = 8,
  parameter logic [7:0] CTL_RST   = 8'h08,
  parameter int         NSLOT     = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [1:0]         op_i,
  input  logic [39:0]        tf_lo_i,
  input  logic [39:0]        tf_hi_i,
  input  logic [7:0]         dev_i,
  input  logic [7:0]         ctl_i,
  input  logic [7:0]         cmd_i,
  input  logic               addr_v_i,
  input  logic               lba48_i,
  input  logic               dev_v_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [NSLOT*8-1:0] rb_o,
  output logic               eng_req_o,
  output logic               eng_wr_o,
  output logic [3:0]         eng_addr_o,
  output logic [7:0]         eng_wdata_o,
  input  logic               eng_done_i,
  input  logic [7:0]         eng_rdata_i
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT} state_e;
  state_e     state;
  op_e        op_q;
  logic [3:0] idx;
  logic [39:0] lo_q, hi_q;
  logic [7:0] dev_q, ctl_q, cmd_q, last_ctl;
  logic       av_q, l48_q, dv_q;
  logic [PW-1:0] polls;
  step_t      st;
  logic [8*14-1:0] src;
  logic [7:0] wmux;

  ata_step_decode u_dec (
    .op(op_q), .idx(idx), .addr_v(av_q), .lba48(l48_q), .dev_v(dv_q),
    .ctl_dirty(ctl_q != last_ctl), .st(st)
  );

  assign src  = {cmd_q, ctl_q | HOB_BIT, ctl_q, dev_q, hi_q, lo_q};
  assign wmux = src[8*st.dsel +: 8];

  ata_rb_store #(.NSLOT(NSLOT), .W(8)) u_store (
    .clk(clk), .rst(rst),
    .cap_i(state == S_WAIT && eng_done_i && st.cap),
    .slot_i(st.slot), .d_i(eng_rdata_i), .rb_o(rb_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; op_q <= OP_NONE; idx <= '0; polls <= '0;
      lo_q <= '0; hi_q <= '0; dev_q <= '0; ctl_q <= '0; cmd_q <= '0;
      av_q <= 1'b0; l48_q <= 1'b0; dv_q <= 1'b0;
      last_ctl <= CTL_RST;
      busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
      eng_req_o <= 1'b0; eng_wr_o <= 1'b0; eng_addr_o <= '0; eng_wdata_o <= '0;
    end else begin
      done_o    <= 1'b0;
      eng_req_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          op_q <= op_e'(op_i); lo_q <= tf_lo_i; hi_q <= tf_hi_i;
          dev_q <= dev_i; ctl_q <= ctl_i; cmd_q <= cmd_i;
          av_q <= addr_v_i; l48_q <= lba48_i; dv_q <= dev_v_i;
          idx <= '0; polls <= '0; err_o <= 1'b0; busy_o <= 1'b1;
          state <= S_STEP;
        end
        S_STEP: begin
          if (!st.en) begin
            if (st.fin) begin
              state <= S_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
            end else idx <= idx + 4'd1;
          end else begin
            eng_req_o <= 1'b1; eng_wr_o <= st.wr;
            eng_addr_o <= st.addr; eng_wdata_o <= wmux;
            state <= S_WAIT;
          end
        end
        S_WAIT: if (eng_done_i) begin
          if (st.upd) last_ctl <= ctl_q;
          if (st.poll && eng_rdata_i[7]) begin
            if (polls == PW'(MAX_POLLS - 1)) begin
              err_o <= 1'b1; state <= S_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
            end else begin
              polls <= polls + 1'b1; state <= S_STEP;
            end
          end else if (st.fin) begin
            state <= S_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
          end else begin
            idx <= idx + 4'd1; state <= S_STEP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a load never sends a control byte equal to the tracked copy
  p_ctl_suppress_r2: assert property (@(posedge clk) disable iff (rst)
    (eng_req_o && eng_wr_o && eng_addr_o == A_CTL && op_q == OP_LOAD) |-> (eng_wdata_o != last_ctl));
  // R10: request is a single-cycle pulse
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |=> !eng_req_o);
  // R10: no new request while a cycle is outstanding
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !eng_done_i) |=> !eng_req_o);
  // R6: timeout flag only appears with completion
  p_err_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);
  // R11: completion leaves the block idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R11: a start while busy leaves the latched operation untouched
  p_ignore_start_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(op_q));
  // R9: command issue is a write of the command byte to status/command
  p_cmd_write_r9: assert property (@(posedge clk) disable iff (rst)
    (eng_req_o && op_q == OP_CMD) |-> (eng_wr_o && eng_addr_o == A_STAT && eng_wdata_o == cmd_q));
endmodule

// File: tb/test_ata_tf_sequencer.sv
`timescale 1ns/1ps
module test_ata_tf_sequencer;
  localparam int MAXP = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [39:0] tf_lo_i = '0, tf_hi_i = '0;
  logic [7:0] dev_i = '0, ctl_i = 8'h08, cmd_i = '0;
  logic addr_v_i = 1'b0, lba48_i = 1'b0, dev_v_i = 1'b0;
  logic busy_o, done_o, err_o, eng_req_o, eng_wr_o, eng_done_i, done_q;
  logic [95:0] rb_o;
  logic [3:0] eng_addr_o;
  logic [7:0] eng_wdata_o, eng_rdata_i;

  always #4 clk = ~clk;

  ata_tf_sequencer #(.MAX_POLLS(MAXP), .CTL_RST(8'h08), .NSLOT(12)) i_ata_tf_sequencer (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .tf_lo_i(tf_lo_i),
    .tf_hi_i(tf_hi_i), .dev_i(dev_i), .ctl_i(ctl_i), .cmd_i(cmd_i),
    .addr_v_i(addr_v_i), .lba48_i(lba48_i), .dev_v_i(dev_v_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rb_o(rb_o),
    .eng_req_o(eng_req_o), .eng_wr_o(eng_wr_o), .eng_addr_o(eng_addr_o),
    .eng_wdata_o(eng_wdata_o), .eng_done_i(eng_done_i), .eng_rdata_i(eng_rdata_i)
  );

  int checks = 0, fails = 0;
  logic [12:0] log_e [0:63];
  logic [12:0] exp_e [0:63];
  int nlog = 0, nexp = 0;
  logic [7:0] m_lo [1:5];
  logic [7:0] m_hi [1:5];
  logic [7:0] m_dev = '0, m_ctl = '0;
  int bsy_left = 0, lat = 1;
  logic [7:0] e_last = 8'h08;
  logic e_err;
  assign done_q = done_o;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive model: address writes shift the low byte into the high copy
  initial begin
    logic [7:0] rd;
    eng_done_i = 1'b0; eng_rdata_i = '0;
    forever begin
      @(negedge clk);
      eng_done_i = 1'b0;
      if (eng_req_o) begin
        if (nlog < 64) log_e[nlog] = {eng_wr_o, eng_addr_o, eng_wr_o ? eng_wdata_o : 8'h00};
        nlog++;
        rd = 8'h00;
        if (eng_wr_o) begin
          if (eng_addr_o >= 4'd1 && eng_addr_o <= 4'd5) begin
            m_hi[eng_addr_o] = m_lo[eng_addr_o]; m_lo[eng_addr_o] = eng_wdata_o;
          end else if (eng_addr_o == 4'd6) m_dev = eng_wdata_o;
          else if (eng_addr_o == 4'hE) m_ctl = eng_wdata_o;
        end else begin
          if (eng_addr_o == 4'd7) begin
            if (bsy_left > 0) begin bsy_left--; rd = 8'hD0; end else rd = 8'h50;
          end else if (eng_addr_o >= 4'd1 && eng_addr_o <= 4'd5)
            rd = m_ctl[7] ? m_hi[eng_addr_o] : m_lo[eng_addr_o];
          else if (eng_addr_o == 4'd6) rd = m_dev;
        end
        repeat (lat - 1) @(negedge clk);
        eng_rdata_i = rd; eng_done_i = 1'b1;
      end
    end
  end

  task automatic push(input bit w, input logic [3:0] a, input logic [7:0] d);
    if (nexp < 64) exp_e[nexp] = {w, a, w ? d : 8'h00};
    nexp++;
  endtask

  task automatic exp_load(input int bsy);
    nexp = 0;
    if (ctl_i != e_last) begin push(1, 4'hE, ctl_i); e_last = ctl_i; end
    if (addr_v_i && lba48_i) for (int k = 0; k < 5; k++) push(1, 4'(k + 1), tf_hi_i[8*k +: 8]);
    if (addr_v_i) for (int k = 0; k < 5; k++) push(1, 4'(k + 1), tf_lo_i[8*k +: 8]);
    if (dev_v_i) push(1, 4'd6, dev_i);
    for (int p = 0; p < ((bsy >= MAXP) ? MAXP : bsy + 1); p++) push(0, 4'd7, 8'h00);
    e_err = (bsy >= MAXP);
  endtask

  task automatic exp_read();
    nexp = 0;
    push(0, 4'd7, 0);
    for (int k = 1; k <= 6; k++) push(0, 4'(k), 0);
    if (lba48_i) begin
      push(1, 4'hE, ctl_i | 8'h80);
      for (int k = 1; k <= 5; k++) push(0, 4'(k), 0);
      push(1, 4'hE, ctl_i);
      e_last = ctl_i;
    end
  endtask

  task automatic cmp_log(input string tag);
    int bad = -1;
    for (int i = 0; i < nexp && i < 64; i++) if (bad < 0 && (i >= nlog || log_e[i] !== exp_e[i])) bad = i;
    if (nlog != nexp) chk(0, {tag, " count"}, 96'(nlog), 96'(nexp));
    else if (bad >= 0) chk(0, {tag, " entry"}, 96'(log_e[bad]), 96'(exp_e[bad]));
    else chk(1, tag, 0, 0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_q && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic go(input logic [1:0] op);
    nlog = 0; op_i = op; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 1; k <= 5; k++) begin m_lo[k] = '0; m_hi[k] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !eng_req_o && rb_o == '0, "R11 reset state",
        {busy_o, done_o, err_o, eng_req_o}, 0);

    // load sweep: every flag combination, control repeated or changed (R1..R6)
    for (int c = 0; c < 16; c++) begin
      lat = (c % 3 == 0) ? 3 : 1;
      {lba48_i, addr_v_i, dev_v_i} = 3'(c);
      ctl_i = c[3] ? e_last : (e_last ^ 8'h02);
      tf_lo_i = {5{8'(c * 17)}} ^ 40'hA1B2C3D4E5;
      tf_hi_i = {5{8'(c * 29)}} ^ 40'h5A6B7C8D9E;
      dev_i = 8'hE0 | 8'(c);
      bsy_left = c % 3;
      exp_load(c % 3);
      go(2'd0);
      cmp_log($sformatf("R1/R2/R3/R4/R5 load combo %0d", c));
      chk(err_o == e_err, "R6 no timeout", err_o, e_err);
    end
    lat = 1;

    // busy-wait boundaries (R6)
    addr_v_i = 0; dev_v_i = 0;
    for (int b = MAXP - 1; b <= MAXP + 1; b++) begin
      bsy_left = b; exp_load(b); go(2'd0);
      cmp_log($sformatf("R6 poll count bsy=%0d", b));
      chk(err_o == e_err, $sformatf("R6 timeout flag bsy=%0d", b), err_o, e_err);
    end
    bsy_left = 0;

    // 48-bit load then readback (R7, R8)
    addr_v_i = 1; lba48_i = 1; dev_v_i = 1; ctl_i = 8'h0A;
    tf_lo_i = 40'h1516171819; tf_hi_i = 40'h2526272829; dev_i = 8'hE3;
    exp_load(0); go(2'd0); cmp_log("R3/R4 48-bit load");
    exp_read(); go(2'd1); cmp_log("R7/R8 48-bit readback order");
    chk(rb_o[7:0] == 8'h50, "R7 status slot", rb_o[7:0], 8'h50);
    chk(rb_o[55:8] == {8'hE3, tf_lo_i}, "R7 low slots", rb_o[55:8], {8'hE3, tf_lo_i});
    chk(rb_o[95:56] == tf_hi_i, "R8 high slots", rb_o[95:56], tf_hi_i);
    // control copy updated by readback: same control not rewritten
    addr_v_i = 0; dev_v_i = 0; exp_load(0); go(2'd0); cmp_log("R8 control copy after readback");

    // command issue (R9)
    cmd_i = 8'h25; nexp = 0; push(1, 4'd7, 8'h25); go(2'd2); cmp_log("R9 command write");

    // start while busy is ignored (R11)
    addr_v_i = 1; lba48_i = 0; dev_v_i = 1; ctl_i = 8'h0A;
    exp_load(0);
    nlog = 0; op_i = 2'd0; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    op_i = 2'd2; start_i = 1'b1; @(negedge clk); start_i = 1'b0; op_i = 2'd0;
    wait_done();
    cmp_log("R11 start while busy ignored");

    // start in the completion cycle is accepted (R11)
    lba48_i = 0; exp_read();
    nlog = 0; op_i = 2'd1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R11 start in done cycle accepted", busy_o, 1);
    wait_done();
    cmp_log("R7/R11 readback after back-to-back start");
    chk(rb_o[55:8] == {8'hE3, tf_lo_i}, "R7 short readback slots", rb_o[55:8], {8'hE3, tf_lo_i});

    // no-op completes without any register cycle (R10)
    nexp = 0; go(2'd3); cmp_log("R10 no-op issues no request");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule